// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

This block gathers 64 interrupt sources into two 32-bit banks and combines them into one interrupt request for a processor. Each source is sampled on the clock. The block records a rising edge as a latched event, except for sources that are fixed as level-sensitive. A level-sensitive source requests service for as long as it stays high. Every bank has an enable mask that gates which of its bits can raise the request.

Software reaches both banks through a small synchronous register bus made up of a 12-bit address, a write strobe, write data and combinational read data. Software reads the latched events, the enables and the live input levels. It acknowledges edge events by writing ones to a clear register. Source numbering runs in reverse across the banks: the low 32 sources land in bank 1 and the high 32 sources land in bank 0.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: Source k (0..63) maps to bank 1 − (k div 32), bit k mod 32. Sources 0..31 therefore appear in bank 1 and sources 32..63 in bank 0.
- R2: `cpu_irq` is a register. After each clock edge it shows whether, before that edge, any bank had a nonzero value of (events OR (levels AND level_sel)) AND enable.
- R3: Bank n occupies addresses 0x010 + 16·n for n in {0,1}. Its offsets are: 0x0 events (read only), 0x4 enable mask (read/write), 0x8 clear (write only, reads zero), 0xC live levels (read only). Read data is combinational from the address and the current state, and a write takes effect at the clock edge where the write strobe is high.
- R4: A bank's levels register holds the value each of its sources had at the previous clock edge.
- R5: An events bit is set when its sampled source goes from 0 to 1, provided the bit is not level-sensitive. The bit stays set after the source falls.
- R6: A write to the clear offset clears each events bit whose write-data bit is 1. Level-sensitive bits are excluded, so a level-sensitive source that is high keeps requesting.
- R7: If a new edge and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R8: The level-sensitive selection is fixed by parameter. By default it is 0x00000000 for bank 0 and 0x1FF00000 for bank 1. Level-sensitive bits never latch events, and they raise the request only while their level is high and enabled.
- R9: Reads at addresses outside 0x010..0x02F, and reads at offsets other than 0x0, 0x4 and 0xC, return zero. Writes anywhere other than the enable and clear offsets change nothing.
- R10: After reset, events, enables and levels are zero in both banks, and `cpu_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 64 | Interrupt sources, bit k is source k |
| bus_addr | input | 12 | Register address within the 4 KB window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| cpu_irq | output | 1 | Registered processor interrupt request |

## Verification
The hardest case to reach from the ports is a source edge that lands on the same clock edge as a clear write to the same bit. The stimulus produces it by raising the source and issuing the clear in the same half-cycle. Level-sensitive bits on a clear that is all ones are the second hard case. The bench drives bank 1 bit 20 high while writing a clear of all ones and confirms that the request holds. A long random phase then mixes sparse source toggles with writes to the decoded offsets and to addresses outside them, and compares every output with a behavioural model on every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BANK_W      = 32;
    localparam int NUM_BANKS   = 2;
    localparam int ADDR_W      = 12;
    localparam int STRIDE_LOG2 = 4;
    localparam int IDX_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int NUM_SRC     = NUM_BANKS * BANK_W;
    localparam logic [ADDR_W-1:0] BANK_BASE = 12'h010;
    localparam logic [ADDR_W-1:0] WIN_END   = BANK_BASE + ADDR_W'(NUM_BANKS << STRIDE_LOG2);

    localparam logic [STRIDE_LOG2-1:0] OFF_EVENTS = 4'h0;
    localparam logic [STRIDE_LOG2-1:0] OFF_ENABLE = 4'h4;
    localparam logic [STRIDE_LOG2-1:0] OFF_CLEAR  = 4'h8;
    localparam logic [STRIDE_LOG2-1:0] OFF_LEVELS = 4'hC;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_EVENTS,
        REG_ENABLE,
        REG_CLEAR,
        REG_LEVELS
    } reg_kind_e;

    typedef struct packed {
        logic [BANK_W-1:0] events;
        logic [BANK_W-1:0] enable;
        logic [BANK_W-1:0] levels;
    } bank_state_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output reg_kind_e         kind
);
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] slot;

    always_comb begin
        rel  = addr - BANK_BASE;
        slot = rel >> STRIDE_LOG2;
        hit  = (slot < ADDR_W'(NUM_BANKS));
        idx  = slot[IDX_W-1:0];
        kind = REG_NONE;
        if (hit) begin
            unique case (addr[STRIDE_LOG2-1:0])
                OFF_EVENTS: kind = REG_EVENTS;
                OFF_ENABLE: kind = REG_ENABLE;
                OFF_CLEAR:  kind = REG_CLEAR;
                OFF_LEVELS: kind = REG_LEVELS;
                default:    kind = REG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter logic [BANK_W-1:0] LEVEL_SEL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src,
    input  logic              enable_we,
    input  logic              clear_we,
    input  logic [BANK_W-1:0] wdata,
    output bank_state_t       state_q_o,
    output logic              pending
);
    bank_state_t state_d, state_q;
    logic [BANK_W-1:0] rise;
    logic [BANK_W-1:0] clr_bits;

    always_comb begin
        state_d  = state_q;
        rise     = src & ~state_q.levels & ~LEVEL_SEL;
        clr_bits = clear_we ? (wdata & ~LEVEL_SEL) : '0;
        state_d.events = (state_q.events & ~clr_bits) | rise;
        state_d.levels = src;
        if (enable_we) begin
            state_d.enable = wdata;
        end
        pending = |((state_q.events | (state_q.levels & LEVEL_SEL)) & state_q.enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_q_o = state_q;

    // R4: levels are the previous-edge sample
    a_r4_levels_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> state_q.levels == $past(src));

    // R5: a fresh edge on an edge-type bit is latched
    a_r5_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q.events & $past(src & ~state_q.levels & ~LEVEL_SEL))
                  == $past(src & ~state_q.levels & ~LEVEL_SEL)));

    // R5: without a clear, latched events never drop
    a_r5_events_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_we |=> ((state_q.events & $past(state_q.events)) == $past(state_q.events)));

    // R6: cleared bits without a coincident edge are gone
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        clear_we |=> ((state_q.events
                       & $past(wdata & ~LEVEL_SEL & ~(src & ~state_q.levels))) == '0));

    // R3: enable write loads the data
    a_r3_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        enable_we |=> state_q.enable == $past(wdata));

    // R8: level-sensitive bits never hold latched events
    a_r8_no_level_latch: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state_q_o.events & LEVEL_SEL) == '0);
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
(
    input  bank_state_t [NUM_BANKS-1:0] banks,
    input  logic                        hit,
    input  logic [IDX_W-1:0]            idx,
    input  reg_kind_e                   kind,
    output logic [BANK_W-1:0]           rdata
);
    bank_state_t sel;

    always_comb begin
        sel   = banks[idx];
        rdata = '0;
        if (hit) begin
            unique case (kind)
                REG_EVENTS: rdata = sel.events;
                REG_ENABLE: rdata = sel.enable;
                REG_LEVELS: rdata = sel.levels;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl
    import irqc_pkg::*;
#(
    parameter logic [NUM_BANKS-1:0][BANK_W-1:0] LEVEL_SELS = {32'h1FF0_0000, 32'h0000_0000}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_src,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [BANK_W-1:0]   bus_wdata,
    output logic [BANK_W-1:0]   bus_rdata,
    output logic                cpu_irq
);
    logic                        dec_hit;
    logic [IDX_W-1:0]            dec_idx;
    reg_kind_e                   dec_kind;
    bank_state_t [NUM_BANKS-1:0] bank_state;
    logic [NUM_BANKS-1:0]        bank_pend;
    logic                        irq_d, irq_q;

    irqc_decode u_decode (
        .addr (bus_addr),
        .hit  (dec_hit),
        .idx  (dec_idx),
        .kind (dec_kind)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic en_we, clr_we;
        assign en_we  = bus_we && dec_hit && (dec_idx == IDX_W'(b)) && (dec_kind == REG_ENABLE);
        assign clr_we = bus_we && dec_hit && (dec_idx == IDX_W'(b)) && (dec_kind == REG_CLEAR);

        irqc_bank #(
            .LEVEL_SEL (LEVEL_SELS[b])
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src       (irq_src[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
            .enable_we (en_we),
            .clear_we  (clr_we),
            .wdata     (bus_wdata),
            .state_q_o (bank_state[b]),
            .pending   (bank_pend[b])
        );
    end

    irqc_rdmux u_rdmux (
        .banks (bank_state),
        .hit   (dec_hit),
        .idx   (dec_idx),
        .kind  (dec_kind),
        .rdata (bus_rdata)
    );

    always_comb begin
        irq_d = |bank_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign cpu_irq = irq_q;

    // R2: request follows bank pending one cycle later
    a_r2_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cpu_irq == $past(|bank_pend));

    // R9: addresses outside the window read zero
    a_r9_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < BANK_BASE || bus_addr >= WIN_END) |-> bus_rdata == '0);

    // R10: request low right after reset
    a_r10_reset_low: assert property (@(posedge clk)
        !rst_n |=> !cpu_irq);
endmodule

// File: tb/dual_bank_irq_ctrl_test.sv
`timescale 1ns/1ps
module dual_bank_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] irq_src;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    always #2.5 clk = ~clk;

    dual_bank_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference
    logic [31:0] m_ev [2];
    logic [31:0] m_en [2];
    logic [31:0] m_lv [2];
    logic        m_irq;
    logic [31:0] m_sel [2];
    initial begin
        m_sel[0] = 32'h0000_0000;
        m_sel[1] = 32'h1FF0_0000;
    end

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int ai, bk, off;
        ai = int'(a);
        if (ai < 16 || ai >= 48) return 32'h0;
        bk  = (ai - 16) / 16;
        off = ai % 16;
        if (off == 0)  return m_ev[bk];
        if (off == 4)  return m_en[bk];
        if (off == 12) return m_lv[bk];
        return 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_ev[i] = '0; m_en[i] = '0; m_lv[i] = '0;
            end
            m_irq = 1'b0;
        end else begin
            logic pend;
            int ai, bk, off;
            pend = 1'b0;
            for (int i = 0; i < 2; i++)
                if (((m_ev[i] | (m_lv[i] & m_sel[i])) & m_en[i]) != 0) pend = 1'b1;
            m_irq = pend;
            ai = int'(bus_addr);
            if (bus_we && ai >= 16 && ai < 48) begin
                bk  = (ai - 16) / 16;
                off = ai % 16;
                if (off == 4) m_en[bk] = bus_wdata;
                if (off == 8) m_ev[bk] = m_ev[bk] & ~(bus_wdata & ~m_sel[bk]);
            end
            for (int k = 0; k < 64; k++) begin
                int b, t;
                b = 1 - (k / 32);
                t = k % 32;
                if (irq_src[k] && !m_lv[b][t] && !m_sel[b][t]) m_ev[b][t] = 1'b1;
                m_lv[b][t] = irq_src[k];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk("R2 cpu_irq vs model", {31'b0, cpu_irq}, {31'b0, m_irq});
            chk("R3 read data vs model", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic set_src(input int k, input logic v);
        @(negedge clk); #1;
        irq_src[k] = v;
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk); #1;
        chk(tag, {31'b0, cpu_irq}, {31'b0, exp});
    endtask

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_src = '0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        rd_chk(12'h010, 32'h0, "R10 bank0 events");
        rd_chk(12'h014, 32'h0, "R10 bank0 enable");
        rd_chk(12'h02C, 32'h0, "R10 bank1 levels");
        irq_chk(1'b0, "R10 cpu_irq low");

        wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h024, 32'hFFFF_FFFF);
        rd_chk(12'h014, 32'hFFFF_FFFF, "R3 enable readback");

        // R1 / R5 source 40 -> bank0 bit8
        set_src(40, 1'b1);
        rd_chk(12'h010, 32'h0000_0100, "R1 source 40 to bank0 bit8");
        set_src(40, 1'b0);
        rd_chk(12'h01C, 32'h0, "R4 level dropped");
        rd_chk(12'h010, 32'h0000_0100, "R5 event kept after fall");
        irq_chk(1'b1, "R2 request from bank0 event");

        set_src(3, 1'b1);
        rd_chk(12'h020, 32'h0000_0008, "R1 source 3 to bank1 bit3");
        rd_chk(12'h02C, 32'h0000_0008, "R4 level high");
        set_src(3, 1'b0);

        // R6 clears
        wr(12'h018, 32'h0000_0100);
        rd_chk(12'h010, 32'h0, "R6 bank0 clear");
        wr(12'h028, 32'h0000_0008);
        rd_chk(12'h020, 32'h0, "R6 bank1 clear");
        idle(1);
        irq_chk(1'b0, "R2 request low after clears");

        // R8 level-sensitive bank1 bit20 (source 20)
        set_src(20, 1'b1);
        rd_chk(12'h02C, 32'h0010_0000, "R8 level visible");
        rd_chk(12'h020, 32'h0, "R8 no latched event");
        irq_chk(1'b1, "R8 level raises request");
        wr(12'h028, 32'hFFFF_FFFF);
        idle(1);
        irq_chk(1'b1, "R6 clear excludes level bits");
        set_src(20, 1'b0);
        idle(1);
        irq_chk(1'b0, "R8 request drops with level");

        // bank0 bit20 is edge type (source 52)
        set_src(52, 1'b1);
        rd_chk(12'h010, 32'h0010_0000, "R8 bank0 bit20 latches");
        set_src(52, 1'b0);

        // enable gating
        wr(12'h014, 32'h0);
        idle(1);
        irq_chk(1'b0, "R2 masked event");
        rd_chk(12'h010, 32'h0010_0000, "R2 masked event still latched");
        wr(12'h014, 32'h0010_0000);
        idle(1);
        irq_chk(1'b1, "R2 enabled event");
        wr(12'h018, 32'h0010_0000);
        idle(1);
        irq_chk(1'b0, "R6 request gone after clear");

        // R7 edge and clear on the same edge: source 37 -> bank0 bit5
        @(negedge clk); #1;
        irq_src[37] = 1'b1; bus_addr = 12'h018; bus_we = 1'b1; bus_wdata = 32'h20;
        @(negedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
        rd_chk(12'h010, 32'h0000_0020, "R7 new edge beats clear");
        wr(12'h018, 32'h20);
        rd_chk(12'h010, 32'h0, "R6 clear with source still high");
        set_src(37, 1'b0);

        // R9 undecoded access
        set_src(33, 1'b1);
        set_src(33, 1'b0);
        wr(12'h010, 32'h0);
        wr(12'h01C, 32'hFFFF_FFFF);
        wr(12'h030, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h015, 32'h0);
        rd_chk(12'h010, 32'h0000_0002, "R9 events unchanged by writes");
        rd_chk(12'h014, 32'h0010_0000, "R9 enable unchanged by odd writes");
        rd_chk(12'h018, 32'h0, "R9 clear offset reads zero");
        rd_chk(12'h011, 32'h0, "R9 unused offset reads zero");
        rd_chk(12'h030, 32'h0, "R9 beyond window reads zero");
        rd_chk(12'h004, 32'h0, "R9 below window reads zero");

        // random traffic, compared each cycle
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); #1;
            irq_src = irq_src ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            bus_we = ($urandom % 3 == 0);
            bus_wdata = $urandom;
            case ($urandom_range(0, 11))
                0: bus_addr = 12'h010;
                1: bus_addr = 12'h014;
                2: bus_addr = 12'h018;
                3: bus_addr = 12'h01C;
                4: bus_addr = 12'h020;
                5: bus_addr = 12'h024;
                6: bus_addr = 12'h028;
                7: bus_addr = 12'h02C;
                8: bus_addr = 12'h030;
                9: bus_addr = 12'h000;
                10: bus_addr = 12'h016;
                default: bus_addr = 12'hFF8;
            endcase
        end
        @(negedge clk); #1 bus_we = 1'b0;
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule